// File: doc/BRIEF.md
# Interrupt Source Pending/Queued Coalescing Unit

This block tracks a two-bit state for each of a small array of interrupt sources. The two bits are P (an event has gone to the downstream queue and awaits end-of-interrupt) and Q (a further trigger came in while P was set). Each source has a hardware trigger input. A trigger that finds the source idle forwards one event, as a one-cycle strobe, toward a downstream event queue. A trigger that finds an event already pending is folded into Q instead. A source is therefore present in the queue at most once.

Software reaches every source through a page of a register-style bus. The source index sits in the address bits above a 12-bit page offset, and the offset selects the operation. A load may read the state, perform end-of-interrupt, or force the state to a chosen value. Each load is an atomic read-modify-write that returns the state as it was before the operation. A store form of end-of-interrupt can be enabled for each source separately.

Top module: `pq_coalesce_top`

## Requirements
- R1: After reset, every source holds PQ = 01 (masked), no forward strobe is active and no response is valid.
- R2: A trigger on a source in state 00 moves it to 10. The source's fwd_o bit is then high for exactly the one cycle after the triggering edge.
- R3: A trigger on a source whose P is set (state 10 or 11) moves it to 11 and forwards nothing.
- R4: A trigger on a source in state 01 leaves it at 01 and forwards nothing.
- R5: A load at offset 0x000 performs end-of-interrupt. If Q was clear, the state becomes 00. If Q was set, the state becomes 10 and a forward strobe is issued in that same cycle.
- R6: A load at offset 0x800 returns the state and leaves it unchanged.
- R7: Loads at offsets 0xC00, 0xD00, 0xE00 and 0xF00 force PQ to 00, 01, 10 and 11 respectively.
- R8: The address is {source index, 12-bit offset}. Every load raises rsp_valid_o in the cycle after the request. For a decoded load, rsp_data_o carries the pre-operation PQ in bits 1:0 (P weight 0x2, Q weight 0x1) and zero in all other bits.
- R9: A store at offset 0x400 performs end-of-interrupt, with the same rules as R5, only when that source's bit of store_eoi_en_i is 1. When the bit is 0 the store has no effect. A store never produces a response.
- R10: A load at any undecoded offset returns zero and leaves the state unchanged. A store at any offset other than 0x400 is ignored.
- R11: When a bus operation and a trigger hit the same source in the same cycle, the bus operation is applied first. The trigger is then evaluated against the resulting state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| trig_i | input | NUM_SRC | Per-source hardware trigger pulse |
| store_eoi_en_i | input | NUM_SRC | Per-source enable for the store form of end-of-interrupt |
| req_valid_i | input | 1 | Bus request valid |
| req_write_i | input | 1 | 1 = store, 0 = load |
| req_addr_i | input | SRC_W+12 | {source index, page offset} |
| rsp_valid_o | output | 1 | Load response valid |
| rsp_data_o | output | DATA_W | Load response word |
| fwd_o | output | NUM_SRC | Per-source one-cycle forward strobe to the event queue |

## Verification
Several properties are checked on every cycle. A source with P set and no bus operation never forwards. A masked source without a bus operation stays masked and silent. A strobe always leaves P set. State moves only under a bus operation or a trigger. Every load gets exactly one response and every store gets none, and response words have zero upper bits. The bench scenarios are needed for the rest: the returned pre-operation values, each forced value, the retrigger on end-of-interrupt, the per-source store enable, undecoded offsets, and the ordering of a bus operation against a trigger in the same cycle.

// File: rtl/pq_pkg.sv
package pq_pkg;
  localparam int PAGE_W = 12;

  localparam logic [PAGE_W-1:0] OFF_EOI_LD = 12'h000;
  localparam logic [PAGE_W-1:0] OFF_EOI_ST = 12'h400;
  localparam logic [PAGE_W-1:0] OFF_GET    = 12'h800;
  localparam logic [PAGE_W-1:0] OFF_SET00  = 12'hC00;
  localparam logic [PAGE_W-1:0] OFF_SET01  = 12'hD00;
  localparam logic [PAGE_W-1:0] OFF_SET10  = 12'hE00;
  localparam logic [PAGE_W-1:0] OFF_SET11  = 12'hF00;

  localparam logic [1:0] PQ_IDLE   = 2'b00;
  localparam logic [1:0] PQ_MASKED = 2'b01;
  localparam logic [1:0] PQ_PEND   = 2'b10;
  localparam logic [1:0] PQ_PENDQ  = 2'b11;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_EOI,
    OP_EOI_ST,
    OP_GET,
    OP_SET
  } pq_op_e;

  typedef struct packed {
    pq_op_e     op;
    logic [1:0] val;
  } pq_cmd_t;
endpackage

// File: rtl/pq_decode.sv
module pq_decode
  import pq_pkg::*;
(
  input  logic              valid_i,
  input  logic              write_i,
  input  logic [PAGE_W-1:0] offset_i,
  output pq_cmd_t           cmd_o
);
  always_comb begin
    cmd_o.op  = OP_NONE;
    cmd_o.val = offset_i[9:8];
    if (valid_i) begin
      if (write_i) begin
        if (offset_i == OFF_EOI_ST) cmd_o.op = OP_EOI_ST;
      end else begin
        unique case (offset_i)
          OFF_EOI_LD: cmd_o.op = OP_EOI;
          OFF_GET:    cmd_o.op = OP_GET;
          OFF_SET00, OFF_SET01, OFF_SET10, OFF_SET11: cmd_o.op = OP_SET;
          default:    cmd_o.op = OP_NONE;
        endcase
      end
    end
  end
endmodule

// File: rtl/pq_cell.sv
module pq_cell
  import pq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sel_i,
  input  pq_cmd_t    cmd_i,
  input  logic       store_en_i,
  input  logic       trig_i,
  output logic [1:0] pq_o,
  output logic       fwd_o
);
  logic [1:0] pq_q, pq_d;
  logic       fwd_q, fwd_d;
  logic       do_eoi;

  assign do_eoi = sel_i && ((cmd_i.op == OP_EOI) ||
                            ((cmd_i.op == OP_EOI_ST) && store_en_i));

  // bus operation first, trigger evaluated on the result
  always_comb begin
    pq_d  = pq_q;
    fwd_d = 1'b0;
    if (do_eoi) begin
      if (pq_q[0]) begin
        pq_d  = PQ_PEND;
        fwd_d = 1'b1;
      end else begin
        pq_d  = PQ_IDLE;
      end
    end else if (sel_i && cmd_i.op == OP_SET) begin
      pq_d = cmd_i.val;
    end
    if (trig_i) begin
      if (pq_d == PQ_IDLE) begin
        pq_d  = PQ_PEND;
        fwd_d = 1'b1;
      end else if (pq_d == PQ_PEND) begin
        pq_d  = PQ_PENDQ;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pq_q  <= PQ_MASKED;
      fwd_q <= 1'b0;
    end else begin
      pq_q  <= pq_d;
      fwd_q <= fwd_d;
    end
  end

  assign pq_o  = pq_q;
  assign fwd_o = fwd_q;
endmodule

// File: rtl/pq_coalesce_top.sv
module pq_coalesce_top
  import pq_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int DATA_W  = 64,
  localparam int SRC_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int ADDR_W = SRC_W + PAGE_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] trig_i,
  input  logic [NUM_SRC-1:0] store_eoi_en_i,
  input  logic               req_valid_i,
  input  logic               req_write_i,
  input  logic [ADDR_W-1:0]  req_addr_i,
  output logic               rsp_valid_o,
  output logic [DATA_W-1:0]  rsp_data_o,
  output logic [NUM_SRC-1:0] fwd_o
);
  pq_cmd_t                 cmd;
  logic [SRC_W-1:0]        src_idx;
  logic                    src_ok;
  logic [NUM_SRC-1:0]      sel;
  logic [NUM_SRC-1:0][1:0] pq_all;
  logic [DATA_W-1:0]       rd_word;
  logic                    rsp_valid_q;
  logic [DATA_W-1:0]       rsp_data_q;

  assign src_idx = req_addr_i[ADDR_W-1:PAGE_W];

  generate
    if (NUM_SRC == (1 << SRC_W)) begin : g_full
      assign src_ok = 1'b1;
    end else begin : g_part
      assign src_ok = (int'(src_idx) < NUM_SRC);
    end
  endgenerate

  pq_decode u_decode (
    .valid_i  (req_valid_i),
    .write_i  (req_write_i),
    .offset_i (req_addr_i[PAGE_W-1:0]),
    .cmd_o    (cmd)
  );

  generate
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      assign sel[i] = req_valid_i && src_ok && (int'(src_idx) == i);
      pq_cell u_cell (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .sel_i      (sel[i]),
        .cmd_i      (cmd),
        .store_en_i (store_eoi_en_i[i]),
        .trig_i     (trig_i[i]),
        .pq_o       (pq_all[i]),
        .fwd_o      (fwd_o[i])
      );
    end
  endgenerate

  always_comb begin
    rd_word = '0;
    if (src_ok && (cmd.op == OP_EOI || cmd.op == OP_GET || cmd.op == OP_SET))
      rd_word[1:0] = pq_all[src_idx];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      rsp_valid_q <= req_valid_i && !req_write_i;
      rsp_data_q  <= rd_word;
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_data_o  = rsp_data_q;
endmodule

// File: rtl/pq_coalesce_chk.sv
module pq_coalesce_chk #(
  parameter int NUM_SRC = 8,
  parameter int DATA_W  = 64
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic [NUM_SRC-1:0]      trig_i,
  input logic                    req_valid_i,
  input logic                    req_write_i,
  input logic                    rsp_valid_o,
  input logic [DATA_W-1:0]       rsp_data_o,
  input logic [NUM_SRC-1:0]      fwd_o,
  input logic [NUM_SRC-1:0]      sel,
  input logic [NUM_SRC-1:0][1:0] pq_all
);
  generate
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_a
      a_r3_merge_no_fwd: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pq_all[i][1] && !sel[i]) |=> !fwd_o[i]);
      a_r4_masked_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pq_all[i] == 2'b01 && !sel[i]) |=> (!fwd_o[i] && pq_all[i] == 2'b01));
      a_r2_fwd_sets_p: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fwd_o[i] |-> pq_all[i][1]);
      a_r10_quiet_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!sel[i] && !trig_i[i]) |=> ($stable(pq_all[i]) && !fwd_o[i]));
    end
  endgenerate

  a_r8_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (rsp_data_o[DATA_W-1:2] == '0));
  a_r8_load_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_write_i) |=> rsp_valid_o);
  a_r9_store_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_write_i) |=> !rsp_valid_o);
  a_r1_no_fwd_idle_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);
endmodule

bind pq_coalesce_top pq_coalesce_chk #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .trig_i      (trig_i),
  .req_valid_i (req_valid_i),
  .req_write_i (req_write_i),
  .rsp_valid_o (rsp_valid_o),
  .rsp_data_o  (rsp_data_o),
  .fwd_o       (fwd_o),
  .sel         (sel),
  .pq_all      (pq_all)
);

// File: tb/pq_coalesce_top_tb.sv
module pq_coalesce_top_tb;
  localparam int NS = 8;
  localparam int AW = 3 + 12;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [NS-1:0] trig_i = '0;
  logic [NS-1:0] store_eoi_en_i = 8'b0000_1000;
  logic          req_valid_i = 1'b0;
  logic          req_write_i = 1'b0;
  logic [AW-1:0] req_addr_i = '0;
  logic          rsp_valid_o;
  logic [63:0]   rsp_data_o;
  logic [NS-1:0] fwd_o;

  int total = 0;
  int bad = 0;

  typedef struct {
    logic [63:0] d;
    string       tag;
  } exp_t;
  exp_t exp_q[$];

  logic [1:0] mpq[NS];

  always #5 clk_i = ~clk_i;

  pq_coalesce_top u_dut (
    .clk_i, .rst_ni, .trig_i, .store_eoi_en_i, .req_valid_i, .req_write_i,
    .req_addr_i, .rsp_valid_o, .rsp_data_o, .fwd_o
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // monitor: pop expected load responses as they appear
  always @(negedge clk_i) begin
    if (rst_ni && rsp_valid_o) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R8 unexpected response", rsp_data_o, 64'h0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(rsp_data_o == e.d, e.tag, rsp_data_o, e.d);
      end
    end
  end

  // driver: one cycle of stimulus, model update, forward check
  task automatic step(input bit v, input bit w, input int src, input logic [11:0] off,
                      input logic [NS-1:0] trg, input string tag);
    logic [NS-1:0] efwd;
    efwd = '0;
    req_valid_i = v;
    req_write_i = w;
    req_addr_i  = {src[2:0], off};
    trig_i      = trg;
    if (v && !w) begin
      exp_t e;
      e.tag = tag;
      e.d = (off == 12'h000 || off == 12'h800 || off[11:10] == 2'b11 && off[7:0] == 8'h00)
            ? {62'b0, mpq[src]} : 64'h0;
      exp_q.push_back(e);
    end
    for (int i = 0; i < NS; i++) begin
      logic [1:0] n;
      bit eoi;
      n = mpq[i];
      eoi = 0;
      if (v && i == src) begin
        if (!w) begin
          if (off == 12'h000) eoi = 1;
          else if (off[11:10] == 2'b11 && off[7:0] == 8'h00) n = off[9:8];
        end else if (off == 12'h400 && store_eoi_en_i[i]) eoi = 1;
        if (eoi) begin
          if (mpq[i][0]) begin n = 2'b10; efwd[i] = 1'b1; end
          else n = 2'b00;
        end
      end
      if (trg[i]) begin
        if (n == 2'b00) begin n = 2'b10; efwd[i] = 1'b1; end
        else if (n == 2'b10) n = 2'b11;
      end
      mpq[i] = n;
    end
    @(posedge clk_i);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    req_write_i = 1'b0;
    trig_i = '0;
    chk(fwd_o == efwd, {tag, " fwd"}, 64'(fwd_o), 64'(efwd));
  endtask

  task automatic ld(input int src, input logic [11:0] off, input string tag);
    step(1, 0, src, off, '0, tag);
  endtask

  task automatic st(input int src, input logic [11:0] off, input string tag);
    step(1, 1, src, off, '0, tag);
  endtask

  task automatic trg(input logic [NS-1:0] t, input string tag);
    step(0, 0, 0, 12'h000, t, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    chk(1'b0, "watchdog", 64'h0, 64'h0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NS; i++) mpq[i] = 2'b01;
    repeat (2) @(negedge clk_i);
    chk(fwd_o == '0, "R1 reset fwd", 64'(fwd_o), 64'h0);
    chk(rsp_valid_o == 1'b0, "R1 reset rsp", 64'(rsp_valid_o), 64'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    for (int i = 0; i < NS; i++) ld(i, 12'h800, "R1 reset state");

    // R2 / R3: basic trigger and coalescing
    ld(0, 12'hC00, "R7 set00");
    trg(8'h01, "R2 trigger idle");
    trg(8'h01, "R3 trigger pending");
    trg(8'h01, "R3 trigger pendq");
    ld(0, 12'h800, "R6 get 11");
    ld(0, 12'h800, "R6 get stable");
    // R5: EOI with and without retrigger
    ld(0, 12'h000, "R5 eoi retrigger");
    ld(0, 12'h800, "R5 after retrigger");
    ld(0, 12'h000, "R5 eoi plain");
    ld(0, 12'h800, "R5 after plain");
    // R4: masked source
    trg(8'h02, "R4 trigger masked");
    ld(1, 12'h800, "R4 still masked");
    ld(1, 12'h000, "R5 eoi on masked");
    ld(1, 12'h800, "R5 masked after eoi");
    // R7: all forced values
    ld(2, 12'hD00, "R7 set01");
    ld(2, 12'hE00, "R7 set10");
    ld(2, 12'hF00, "R7 set11");
    ld(2, 12'hC00, "R7 set00 back");
    ld(2, 12'h800, "R7 final get");
    // R9: store EOI, enabled on src3 only
    ld(3, 12'hF00, "R9 prep3");
    st(3, 12'h400, "R9 store eoi enabled");
    ld(3, 12'h800, "R9 state3");
    ld(4, 12'hF00, "R9 prep4");
    st(4, 12'h400, "R9 store eoi disabled");
    ld(4, 12'h800, "R9 state4");
    // R10: undecoded offsets
    ld(5, 12'hE00, "R10 prep5");
    ld(5, 12'h404, "R10 undecoded load");
    ld(5, 12'hC10, "R10 undecoded near set");
    st(5, 12'h000, "R10 store ignored");
    st(5, 12'hC00, "R10 store set ignored");
    ld(5, 12'h800, "R10 state5 unchanged");
    // R11: bus and trigger same cycle
    ld(6, 12'hF00, "R11 prep6");
    step(1, 0, 6, 12'hC00, 8'h40, "R11 set00 plus trigger");
    ld(6, 12'h800, "R11 state6");
    step(1, 0, 6, 12'h000, 8'h40, "R11 eoi plus trigger");
    ld(6, 12'h800, "R11 state6 again");
    ld(6, 12'hE00, "R11 prep pending");
    step(1, 0, 6, 12'h000, 8'h40, "R11 eoi pending plus trigger");
    ld(6, 12'h800, "R11 state6 final");
    // several sources at once, back-to-back
    ld(7, 12'hC00, "R2 prep7");
    trg(8'hFF, "R2 wide trigger");
    trg(8'hFF, "R3 wide trigger");
    for (int i = 0; i < NS; i++) ld(i, 12'h800, "R8 sweep");
    for (int i = 0; i < NS; i++) ld(i, 12'h000, "R5 sweep eoi");
    for (int i = 0; i < NS; i++) ld(i, 12'h800, "R8 sweep after eoi");

    @(negedge clk_i);
    chk(exp_q.size() == 0, "R8 all responses seen", 64'(exp_q.size()), 64'h0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule